// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block keeps a set of event counters for a processor core. It has a parameterised number of general-purpose counters, each with its own event-select register, and up to three fixed-function counters. The fixed-function counters share one control register made of packed 4-bit fields. Upstream logic decodes events into one pulse per counter per cycle. A privilege input tells the block whether the current cycle runs at user or kernel level. A counter advances only when both its local enable and its bit in the global control register are set. It must also be enabled for the current privilege level.

When a counter wraps from all ones to zero, a sticky bit is set in the global status register. If that counter's interrupt enable is set, the level interrupt output rises. Software clears status bits by writing ones to a separate overflow-clear register. A direct write to the status register is refused.

Software has a simple register port. Reads return data in the same cycle. Every access raises a one-cycle error flag in the cycle after it if the access is invalid. A second port reads any counter by index, with an optional 32-bit fast mode.

Top module: `perf_ctr_unit`

## Requirements
- R1: After reset, every counter, event-select register, the fixed control, global control, global status and overflow-clear registers read as zero, and the interrupt and error outputs are low.
- R2: An event-select register (address 0x10+i) holds the event code in bits 7:0 and the unit mask in bits 15:8. Bit 16 enables counting at user level, bit 17 at kernel level, bit 20 enables the overflow interrupt and bit 22 is the local enable. A write with bit 21 or any of bits 63:32 set is refused with an error and leaves the register unchanged.
- R3: General-purpose counter i (address 0x20+i) increments on its event pulse only when event-select bit 22 is set, global control bit i is set, and the privilege enable for the current level is set (bit 16 when evt_user is 1, bit 17 when it is 0).
- R4: Fixed counter j (address 0x30+j) is configured by bits 4j+3..4j of the fixed control register (address 0x00). Bit 4j enables kernel counting, bit 4j+1 enables user counting and bit 4j+3 enables its interrupt. It counts only while global control bit 32+j is set. A write that sets any bit 4j+2, or any bit at or above 4*NUM_FIX, is refused with an error.
- R5: A counter that increments from all ones wraps to zero and sets its status bit (address 0x02): bit i for general-purpose counter i, bit 32+j for fixed counter j.
- R6: ovf_irq is high exactly while some status bit is set whose counter has its interrupt enable set. It stays high across idle cycles until those bits are cleared.
- R7: A write to the status register is always refused with an error and changes no status bit.
- R8: A write to the overflow-clear register (address 0x03) clears every status bit where the data has a 1 and stores the data for read-back. It is refused if it sets any bit outside the implemented counter positions other than bits 63:62.
- R9: A counter write loads bits 31:0 of the data sign-extended to the 48-bit counter width. Reads return the counter zero-extended to 64 bits.
- R10: When a software write and an event pulse hit the same counter in one cycle, the written value is kept and the event is lost.
- R11: On the index port, bit 30 selects the fixed counters and bits 29:0 give the counter number. Bit 31 returns only the low 32 bits of the count. A number beyond the implemented counters raises pmc_err and returns zero.
- R12: A global control write (address 0x01) that sets bits other than 0..NUM_GP-1 and 32..32+NUM_FIX-1 is refused with an error. So is any read or write of an unmapped address.
- R13: Register reads return data in the same cycle without a clock edge. reg_err reports an access in the cycle after it and stays low in the access cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used only to flag invalid reads) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| reg_err | output | 1 | Registered error for the previous access |
| gp_evt | input | NUM_GP | Event pulses for the general-purpose counters |
| fx_evt | input | NUM_FIX | Event pulses for the fixed counters |
| evt_user | input | 1 | 1 when the current cycle runs at user level, 0 at kernel level |
| pmc_idx | input | 32 | Counter index for the index read port |
| pmc_data | output | 64 | Counter value selected by pmc_idx |
| pmc_err | output | 1 | pmc_idx names no implemented counter |
| ovf_irq | output | 1 | Level overflow interrupt |

## Verification
A counter that miscounts or misses a gate shows at its read address at the next falling edge. The bench compares every register each cycle, so a bad increment is reported within one cycle. A lost or stray overflow shows at once in the status read-back and in ovf_irq. An acceptance check that wrongly passes or refuses a write shows one cycle later on reg_err, and in the next read of the target register.

// File: rtl/perf_ctr_unit.sv
`timescale 1ns/1ps
module perf_ctr_unit #(
  parameter int NUM_GP  = 4,   // 1..16
  parameter int NUM_FIX = 3,   // 1..3
  parameter int CTR_W   = 48   // 33..63
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [7:0]          reg_addr,
  input  logic [63:0]         reg_wdata,
  output logic [63:0]         reg_rdata,
  output logic                reg_err,
  input  logic [NUM_GP-1:0]   gp_evt,
  input  logic [NUM_FIX-1:0]  fx_evt,
  input  logic                evt_user,
  input  logic [31:0]         pmc_idx,
  output logic [63:0]         pmc_data,
  output logic                pmc_err,
  output logic                ovf_irq
);
  function automatic logic [63:0] fix_bad_mask();
    logic [63:0] m;
    m = ~((64'd1 << (4*NUM_FIX)) - 64'd1);
    for (int j = 0; j < NUM_FIX; j++) m[4*j+2] = 1'b1;
    return m;
  endfunction

  localparam logic [63:0] GP_BITS  = (64'd1 << NUM_GP) - 64'd1;
  localparam logic [63:0] FIX_BITS = ((64'd1 << NUM_FIX) - 64'd1) << 32;
  localparam logic [63:0] IMPL     = GP_BITS | FIX_BITS;
  localparam logic [63:0] CLR_OK   = IMPL | {2'b11, 62'd0};
  localparam logic [63:0] SEL_BAD  = 64'hFFFF_FFFF_0020_0000;
  localparam logic [63:0] FIX_BAD  = fix_bad_mask();
  localparam logic [3:0]  RG_GLB = 4'h0, RG_SEL = 4'h1, RG_GP = 4'h2, RG_FIX = 4'h3;

  logic [CTR_W-1:0] gp_cnt [NUM_GP];
  logic [CTR_W-1:0] fx_cnt [NUM_FIX];
  logic [63:0]      evsel  [NUM_GP];
  logic [63:0]      fctl, gctl, status, clr_reg;

  wire [3:0] rg = reg_addr[7:4];
  wire [3:0] ix = reg_addr[3:0];

  logic addr_ok, wr_ok;

  always_comb begin
    addr_ok   = 1'b0;
    wr_ok     = 1'b0;
    reg_rdata = '0;
    case (rg)
      RG_GLB: begin
        case (ix)
          4'h0: begin addr_ok = 1'b1; wr_ok = (reg_wdata & FIX_BAD) == '0; reg_rdata = fctl;    end
          4'h1: begin addr_ok = 1'b1; wr_ok = (reg_wdata & ~IMPL) == '0;  reg_rdata = gctl;    end
          4'h2: begin addr_ok = 1'b1; wr_ok = 1'b0;                       reg_rdata = status;  end
          4'h3: begin addr_ok = 1'b1; wr_ok = (reg_wdata & ~CLR_OK) == '0; reg_rdata = clr_reg; end
          default: ;
        endcase
      end
      RG_SEL:
        for (int i = 0; i < NUM_GP; i++)
          if (ix == 4'(i)) begin
            addr_ok = 1'b1; wr_ok = (reg_wdata & SEL_BAD) == '0; reg_rdata = evsel[i];
          end
      RG_GP:
        for (int i = 0; i < NUM_GP; i++)
          if (ix == 4'(i)) begin
            addr_ok = 1'b1; wr_ok = 1'b1; reg_rdata = 64'(gp_cnt[i]);
          end
      RG_FIX:
        for (int j = 0; j < NUM_FIX; j++)
          if (ix == 4'(j)) begin
            addr_ok = 1'b1; wr_ok = 1'b1; reg_rdata = 64'(fx_cnt[j]);
          end
      default: ;
    endcase
  end

  wire              wr_go  = reg_wr & wr_ok;
  wire              clr_go = wr_go && rg == RG_GLB && ix == 4'h3;
  wire [CTR_W-1:0]  ld_val = CTR_W'({{32{reg_wdata[31]}}, reg_wdata[31:0]});

  logic [NUM_GP-1:0]  gp_inc, gp_ld;
  logic [NUM_FIX-1:0] fx_inc, fx_ld;
  logic [63:0]        ovf_set, irq_en;

  always_comb begin
    ovf_set = '0;
    irq_en  = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      gp_ld[i]   = wr_go && rg == RG_GP && ix == 4'(i);
      gp_inc[i]  = gp_evt[i] && evsel[i][22] && gctl[i] &&
                   (evt_user ? evsel[i][16] : evsel[i][17]);
      ovf_set[i] = gp_inc[i] && !gp_ld[i] && (&gp_cnt[i]);
      irq_en[i]  = evsel[i][20];
    end
    for (int j = 0; j < NUM_FIX; j++) begin
      fx_ld[j]      = wr_go && rg == RG_FIX && ix == 4'(j);
      fx_inc[j]     = fx_evt[j] && gctl[32+j] &&
                      (evt_user ? fctl[4*j+1] : fctl[4*j]);
      ovf_set[32+j] = fx_inc[j] && !fx_ld[j] && (&fx_cnt[j]);
      irq_en[32+j]  = fctl[4*j+3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GP; i++) begin
        gp_cnt[i] <= '0;
        evsel[i]  <= '0;
      end
      for (int j = 0; j < NUM_FIX; j++) fx_cnt[j] <= '0;
      fctl    <= '0;
      gctl    <= '0;
      status  <= '0;
      clr_reg <= '0;
      reg_err <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_GP; i++) begin
        if (gp_ld[i])       gp_cnt[i] <= ld_val;
        else if (gp_inc[i]) gp_cnt[i] <= gp_cnt[i] + CTR_W'(1);
        if (wr_go && rg == RG_SEL && ix == 4'(i)) evsel[i] <= reg_wdata;
      end
      for (int j = 0; j < NUM_FIX; j++) begin
        if (fx_ld[j])       fx_cnt[j] <= ld_val;
        else if (fx_inc[j]) fx_cnt[j] <= fx_cnt[j] + CTR_W'(1);
      end
      if (wr_go && rg == RG_GLB) begin
        case (ix)
          4'h0: fctl    <= reg_wdata;
          4'h1: gctl    <= reg_wdata;
          4'h3: clr_reg <= reg_wdata;
          default: ;
        endcase
      end
      status  <= (clr_go ? (status & ~reg_wdata) : status) | ovf_set;
      reg_err <= reg_wr ? !wr_ok : (reg_rd && !addr_ok);
    end
  end

  assign ovf_irq = |(status & irq_en);

  logic [CTR_W-1:0] pmc_val;
  always_comb begin
    pmc_val = '0;
    pmc_err = 1'b1;
    if (pmc_idx[30]) begin
      for (int j = 0; j < NUM_FIX; j++)
        if (pmc_idx[29:0] == 30'(j)) begin pmc_val = fx_cnt[j]; pmc_err = 1'b0; end
    end else begin
      for (int i = 0; i < NUM_GP; i++)
        if (pmc_idx[29:0] == 30'(i)) begin pmc_val = gp_cnt[i]; pmc_err = 1'b0; end
    end
    if (pmc_err)          pmc_data = '0;
    else if (pmc_idx[31]) pmc_data = {32'd0, pmc_val[31:0]};
    else                  pmc_data = 64'(pmc_val);
  end

  // R7
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h02) |=> reg_err);

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_go |=> ((status & $past(status)) == $past(status)));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (status != '0));

  // R11
  fast_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmc_idx[31] |-> (pmc_data[63:32] == 32'd0));

  // R12
  gctl_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h01 && (reg_wdata & ~IMPL) != '0) |=> ($stable(gctl) && reg_err));
endmodule

// File: tb/perf_ctr_unit_bench.sv
`timescale 1ns/1ps
module perf_ctr_unit_bench;
  localparam int NG = 4, NF = 3;
  localparam logic [63:0] IMPL   = 64'h0000_0007_0000_000F;
  localparam logic [63:0] FXBAD  = 64'hFFFF_FFFF_FFFF_F444;
  localparam logic [63:0] SELBAD = 64'hFFFF_FFFF_0020_0000;
  localparam logic [63:0] CLROK  = IMPL | 64'hC000_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, evt_user = 0;
  logic [7:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata, pmc_data;
  logic reg_err, pmc_err, ovf_irq;
  logic [NG-1:0] gp_evt = 0;
  logic [NF-1:0] fx_evt = 0;
  logic [31:0] pmc_idx = 0;

  always #4 clk = ~clk;

  perf_ctr_unit #(.NUM_GP(NG), .NUM_FIX(NF), .CTR_W(48)) u_perf_ctr_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err), .gp_evt(gp_evt),
    .fx_evt(fx_evt), .evt_user(evt_user), .pmc_idx(pmc_idx), .pmc_data(pmc_data),
    .pmc_err(pmc_err), .ovf_irq(ovf_irq));

  logic [47:0] m_gp [NG], n_gp [NG];
  logic [47:0] m_fx [NF], n_fx [NF];
  logic [63:0] m_sel [NG], n_sel [NG];
  logic [63:0] m_fctl, m_gctl, m_stat, m_clr, n_fctl, n_gctl, n_stat, n_clr;
  logic m_err, n_err;
  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic logic [47:0] sx(input logic [63:0] d);
    return {{16{d[31]}}, d[31:0]};
  endfunction

  function automatic logic valid(input logic [7:0] a);
    return (a <= 8'h03) || (a >= 8'h10 && a < 8'(16+NG)) ||
           (a >= 8'h20 && a < 8'(32+NG)) || (a >= 8'h30 && a < 8'(48+NF));
  endfunction

  function automatic logic acc(input logic [7:0] a, input logic [63:0] d);
    if (a == 8'h00) return (d & FXBAD) == 0;
    if (a == 8'h01) return (d & ~IMPL) == 0;
    if (a == 8'h02) return 1'b0;
    if (a == 8'h03) return (d & ~CLROK) == 0;
    if (a >= 8'h10 && a < 8'(16+NG)) return (d & SELBAD) == 0;
    return valid(a);
  endfunction

  function automatic logic [63:0] mread(input logic [7:0] a);
    if (a == 8'h00) return m_fctl;
    if (a == 8'h01) return m_gctl;
    if (a == 8'h02) return m_stat;
    if (a == 8'h03) return m_clr;
    for (int i = 0; i < NG; i++) begin
      if (a == 8'(16+i)) return m_sel[i];
      if (a == 8'(32+i)) return {16'd0, m_gp[i]};
    end
    for (int j = 0; j < NF; j++) if (a == 8'(48+j)) return {16'd0, m_fx[j]};
    return 64'd0;
  endfunction

  function automatic logic exp_irq();
    logic [63:0] ie = 0;
    for (int i = 0; i < NG; i++) ie[i] = m_sel[i][20];
    for (int j = 0; j < NF; j++) ie[32+j] = m_fctl[4*j+3];
    return |(m_stat & ie);
  endfunction

  function automatic logic [64:0] pmc_exp(input logic [31:0] idx);
    logic [47:0] v;
    if (idx[30]) begin
      if (idx[29:0] >= 30'(NF)) return {1'b1, 64'd0};
      v = m_fx[idx[1:0]];
    end else begin
      if (idx[29:0] >= 30'(NG)) return {1'b1, 64'd0};
      v = m_gp[idx[1:0]];
    end
    return {1'b0, idx[31] ? {32'd0, v[31:0]} : {16'd0, v}};
  endfunction

  task automatic drive(input logic w, input logic r, input logic [7:0] a, input logic [63:0] d,
                       input logic [NG-1:0] ge, input logic [NF-1:0] fe, input logic u);
    logic ok, inc;
    logic [63:0] set;
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; gp_evt = ge; fx_evt = fe; evt_user = u;
    ok = w && acc(a, d);
    n_err = w ? !acc(a, d) : (r && !valid(a));
    set = 0;
    for (int i = 0; i < NG; i++) begin
      inc = ge[i] && m_sel[i][22] && m_gctl[i] && (u ? m_sel[i][16] : m_sel[i][17]);
      n_gp[i] = m_gp[i];
      if (ok && a == 8'(32+i)) n_gp[i] = sx(d);
      else if (inc) begin
        if (&m_gp[i]) set[i] = 1'b1;
        n_gp[i] = m_gp[i] + 48'd1;
      end
      n_sel[i] = (ok && a == 8'(16+i)) ? d : m_sel[i];
    end
    for (int j = 0; j < NF; j++) begin
      inc = fe[j] && m_gctl[32+j] && (u ? m_fctl[4*j+1] : m_fctl[4*j]);
      n_fx[j] = m_fx[j];
      if (ok && a == 8'(48+j)) n_fx[j] = sx(d);
      else if (inc) begin
        if (&m_fx[j]) set[32+j] = 1'b1;
        n_fx[j] = m_fx[j] + 48'd1;
      end
    end
    n_fctl = (ok && a == 8'h00) ? d : m_fctl;
    n_gctl = (ok && a == 8'h01) ? d : m_gctl;
    n_clr  = (ok && a == 8'h03) ? d : m_clr;
    n_stat = ((ok && a == 8'h03) ? (m_stat & ~d) : m_stat) | set;
  endtask

  task automatic sweep(input string tag);
    logic [7:0] list [14] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h12, 8'h13,
                              8'h20, 8'h21, 8'h22, 8'h23, 8'h30, 8'h31};
    for (int k = 0; k < 14; k++) begin
      reg_addr = list[k];
      #0.1;
      chk($sformatf("%s addr %h", tag, list[k]), reg_rdata, mread(list[k]));
    end
    reg_addr = 8'h32;
    #0.1;
    chk($sformatf("%s addr 32", tag), reg_rdata, mread(8'h32));
  endtask

  task automatic commit(input string tag);
    @(posedge clk);
    for (int i = 0; i < NG; i++) begin m_gp[i] = n_gp[i]; m_sel[i] = n_sel[i]; end
    for (int j = 0; j < NF; j++) m_fx[j] = n_fx[j];
    m_fctl = n_fctl; m_gctl = n_gctl; m_stat = n_stat; m_clr = n_clr; m_err = n_err;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; gp_evt = 0; fx_evt = 0;
    chk({tag, " R13 err"}, {63'd0, reg_err}, {63'd0, m_err});
    chk({tag, " R6 irq"}, {63'd0, ovf_irq}, {63'd0, exp_irq()});
    sweep(tag);
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [63:0] d,
                     input logic [NG-1:0] ge, input logic [NF-1:0] fe, input logic u, input string tag);
    drive(w, r, a, d, ge, fe, u);
    commit(tag);
  endtask

  task automatic idx_chk(input logic [31:0] idx, input string tag);
    logic [64:0] e;
    pmc_idx = idx;
    #0.1;
    e = pmc_exp(idx);
    chk({tag, " data"}, pmc_data, e[63:0]);
    chk({tag, " err"}, {63'd0, pmc_err}, {63'd0, e[64]});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NG; i++) begin m_gp[i] = 0; m_sel[i] = 0; end
    for (int j = 0; j < NF; j++) m_fx[j] = 0;
    m_fctl = 0; m_gctl = 0; m_stat = 0; m_clr = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 err", {63'd0, reg_err}, 64'd0);
    chk("R1 irq", {63'd0, ovf_irq}, 64'd0);
    sweep("R1");

    cyc(1, 0, 8'h01, 64'h10, 0, 0, 0, "R12 bad gctl");
    cyc(1, 0, 8'h55, 64'h1, 0, 0, 0, "R12 unmapped write");
    cyc(0, 1, 8'h17, 64'h0, 0, 0, 0, "R12 unmapped read");
    cyc(1, 0, 8'h01, IMPL, 0, 0, 0, "R12 gctl ok");
    chk("R12 gctl value", mread(8'h01), IMPL);

    cyc(1, 0, 8'h10, 64'h0060_00C0, 0, 0, 0, "R2 bit21");
    cyc(1, 0, 8'h10, 64'h1_0040_00C0, 0, 0, 0, "R2 high bits");
    cyc(1, 0, 8'h10, 64'h0041_1AC0, 0, 0, 0, "R2 user only");
    cyc(0, 0, 0, 0, 4'h1, 0, 0, "R3 kernel ignored");
    chk("R3 no kernel count", mread(8'h20), 64'd0);
    cyc(0, 0, 0, 0, 4'h1, 0, 1, "R3 user counts");
    chk("R3 user count", mread(8'h20), 64'd1);
    cyc(1, 0, 8'h01, 64'h7_0000_000E, 0, 0, 0, "R3 gctl off");
    cyc(0, 0, 0, 0, 4'h1, 0, 1, "R3 global gate");
    chk("R3 gated", mread(8'h20), 64'd1);
    cyc(1, 0, 8'h01, IMPL, 0, 0, 0, "R3 gctl on");

    cyc(1, 0, 8'h21, 64'h8000_0000, 0, 0, 0, "R9 negative");
    chk("R9 sext", mread(8'h21), 64'h0000_FFFF_8000_0000);
    cyc(1, 0, 8'h21, 64'hABCD_0000_7FFF_FFFF, 0, 0, 0, "R9 positive");
    chk("R9 low32", mread(8'h21), 64'h0000_0000_7FFF_FFFF);

    cyc(1, 0, 8'h10, 64'h0053_0000, 0, 0, 0, "R2 int en");
    cyc(1, 0, 8'h20, 64'hFFFF_FFFF, 0, 0, 0, "R5 preload");
    cyc(0, 0, 0, 0, 4'h1, 0, 0, "R5 wrap");
    chk("R5 wrapped", mread(8'h20), 64'd0);
    chk("R5 status", mread(8'h02), 64'h1);
    chk("R6 irq high", {63'd0, ovf_irq}, 64'd1);
    cyc(0, 0, 0, 0, 0, 0, 0, "R6 hold");
    chk("R6 irq held", {63'd0, ovf_irq}, 64'd1);

    cyc(1, 0, 8'h02, 64'h0, 0, 0, 0, "R7 zero write");
    cyc(1, 0, 8'h02, '1, 0, 0, 0, "R7 ones write");
    chk("R7 status kept", mread(8'h02), 64'h1);

    cyc(1, 0, 8'h03, 64'h400, 0, 0, 0, "R8 bad clear");
    cyc(1, 0, 8'h03, 64'hC000_0000_0000_0000, 0, 0, 0, "R8 top bits");
    chk("R8 stored", mread(8'h03), 64'hC000_0000_0000_0000);
    cyc(1, 0, 8'h03, 64'h1, 0, 0, 0, "R8 clear");
    chk("R8 cleared", mread(8'h02), 64'h0);
    chk("R8 irq low", {63'd0, ovf_irq}, 64'd0);

    cyc(1, 0, 8'h00, 64'h4, 0, 0, 0, "R4 bit2");
    cyc(1, 0, 8'h00, 64'h1000, 0, 0, 0, "R4 above fields");
    cyc(1, 0, 8'h00, 64'hB21, 0, 0, 0, "R4 fields");
    cyc(0, 0, 0, 0, 0, 3'h7, 0, "R4 kernel");
    cyc(0, 0, 0, 0, 0, 3'h7, 1, "R4 user");
    chk("R4 fx0", mread(8'h30), 64'd1);
    chk("R4 fx1", mread(8'h31), 64'd1);
    chk("R4 fx2", mread(8'h32), 64'd2);
    cyc(1, 0, 8'h32, 64'hFFFF_FFFF, 0, 0, 0, "R5 fx preload");
    cyc(0, 0, 0, 0, 0, 3'h4, 1, "R5 fx wrap");
    chk("R5 fx status", mread(8'h02), 64'h4_0000_0000);
    chk("R6 fx irq", {63'd0, ovf_irq}, 64'd1);

    cyc(1, 0, 8'h20, 64'h5, 4'h1, 0, 0, "R10 collide");
    chk("R10 write wins", mread(8'h20), 64'd5);

    drive(1, 0, 8'h02, 64'h0, 0, 0, 0);
    #1;
    chk("R13 err not early", {63'd0, reg_err}, 64'd0);
    commit("R13 late err");

    cyc(1, 0, 8'h22, 64'h9234_5678, 0, 0, 0, "R11 load");
    idx_chk(32'h0000_0002, "R11 full");
    chk("R11 full value", pmc_data, 64'h0000_FFFF_9234_5678);
    idx_chk(32'h8000_0002, "R11 fast");
    chk("R11 fast value", pmc_data, 64'h0000_0000_9234_5678);
    idx_chk(32'h4000_0001, "R11 fixed");
    idx_chk(32'h4000_0003, "R11 fixed range");
    idx_chk(32'h0000_0004, "R11 gp range");
    idx_chk(32'h2000_0000, "R11 high number");

    for (int n = 0; n < 3000; n++) begin
      logic w, r, u;
      logic [7:0] a;
      logic [63:0] d, raw;
      int kind;
      w = ($urandom % 4) == 0;
      r = !w && (($urandom % 8) == 0);
      kind = $urandom % 5;
      case (kind)
        0: a = 8'($urandom % 5);
        1: a = 8'(16 + $urandom % (NG + 1));
        2: a = 8'(32 + $urandom % (NG + 1));
        3: a = 8'(48 + $urandom % (NF + 1));
        default: a = 8'($urandom);
      endcase
      raw = {$urandom, $urandom};
      d = raw;
      if (($urandom % 4) != 0) begin
        if (a == 8'h00) d = raw & ~FXBAD;
        else if (a == 8'h01) d = raw | IMPL & (raw | 64'h1_0000_0003) & IMPL;
        else if (a == 8'h03) d = raw & CLROK;
        else if (a[7:4] == 4'h1) d = (raw & ~SELBAD) | 64'h0040_0000;
        else if (a[7:4] >= 4'h2) d = {32'd0, 28'hFFFF_FFF, 4'($urandom)};
      end
      u = 1'($urandom);
      cyc(w, r, a, d, NG'($urandom), NF'($urandom), u, "R3 R4 R5 random");
      idx_chk({1'($urandom), 1'($urandom), 27'd0, 3'($urandom % 6)}, "R11 random");
    end

    finish_run();
  end
endmodule